// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one successive-approximation conversion for an external
converter front end. After a start request it steps through up to three
phases: an initial sample phase whose length is chosen per command (and which
can be skipped), a final sample phase of fixed length, and a resolution phase.
In the resolution phase it presents a trial code to an external DAC once per
clock. It reads one comparator bit back in the same cycle and settles one
result bit per clock, from the most significant bit down.

The comparator input `cmp_hi_i` is 1 when the DAC output for the presented
trial code is above the analog input. When the last bit is settled, the block
loads the finished code into a holding register and pulses `done_o` for one
clock. The total conversion time therefore changes with the bypass input and
the sample-length select.

Top module: `sar_conv_ctrl`

## Requirements
- R1: The first trial code of every resolution phase is half scale: only the most significant bit is set (512 for 10 bits).
- R2: In each resolution cycle the trial bit is cleared if `cmp_hi_i` is 1 in that cycle and kept if it is 0. Lower bits are then tried one per cycle.
- R3: With an ideal comparator (`cmp_hi_i` = trial code greater than input value), the final code equals the input value for every input from 0 to 1023. An input of one third of full scale resolves to 341, and to 85 for an 8-bit instance.
- R4: A start request accepted while idle raises `busy_o` from the next cycle. `busy_o` then stays high for exactly L + 2 + 10 cycles, where L is the initial sample length, and falls in the cycle in which `done_o` is high.
- R5: With `bypass_i` = 1 at start, the initial sample phase is skipped, and `busy_o` lasts 12 cycles.
- R6: `init_sel_i` values 0, 1, 2, 3 select an initial sample length of 2, 4, 8 and 16 clocks.
- R7: `start_i` has no effect while `busy_o` is high. It changes neither the timing nor the result, and no second conversion follows.
- R8: `done_o` is high for exactly one cycle per conversion, `busy_o` is low in that cycle, and `code_o` is already valid in that cycle.
- R9: `code_o` keeps its value until the next conversion completes.
- R10: After reset `busy_o`, `done_o`, `code_o` and `dac_code_o` are 0. `dac_code_o` is 0 whenever no resolution is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a conversion (used only while idle) |
| bypass_i | input | 1 | Skip the initial sample phase for this conversion |
| init_sel_i | input | 2 | Initial sample length select |
| cmp_hi_i | input | 1 | Comparator: DAC output above the analog input |
| dac_code_o | output | 10 | Trial code for the external DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 10 | Last completed conversion result |

## Verification
The hardest condition to create is a start request that arrives in the middle of a conversion, in a phase where it could plausibly restart or reload the sequencer. The stimulus therefore raises `start_i` together with `bypass_i` a few cycles into a long conversion. The scoreboard then confirms that the busy length and result stay at the values of the first command and that the block stays idle afterwards. A second 8-bit instance shares the start stimulus, so the resolution length follows from the width parameter.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_INIT    = 2'd1,
      PH_FINAL   = 2'd2,
      PH_RESOLVE = 2'd3
   } sar_phase_t;

endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
   import sar_pkg::*;
#(
   parameter int CODE_W    = 10,
   parameter int SEL_W     = 2,
   parameter int INIT_BASE = 2,
   parameter int FINAL_LEN = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       bypass,
   input  logic [SEL_W-1:0]           init_sel,
   output sar_phase_t                 phase,
   output logic                       launch,
   output logic                       res_active,
   output logic                       res_last,
   output logic [$clog2(CODE_W)-1:0]  bit_idx
);

   localparam int NUM_SEL  = 1 << SEL_W;
   localparam int MAX_INIT = INIT_BASE << (NUM_SEL - 1);
   localparam int MAX_A    = (MAX_INIT > FINAL_LEN) ? MAX_INIT : FINAL_LEN;
   localparam int MAX_LEN  = (MAX_A > CODE_W) ? MAX_A : CODE_W;
   localparam int CNT_W    = $clog2(MAX_LEN + 1);
   localparam int IDX_W    = $clog2(CODE_W);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] len_tab [NUM_SEL];

   generate
      for (genvar s = 0; s < NUM_SEL; s++) begin : g_len
         assign len_tab[s] = CNT_W'(INIT_BASE << s);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  if (bypass) begin
                     phase <= PH_FINAL;
                     cnt   <= CNT_W'(FINAL_LEN - 1);
                  end else begin
                     phase <= PH_INIT;
                     cnt   <= len_tab[init_sel] - CNT_W'(1);
                  end
               end
            end
            PH_INIT: begin
               if (cnt == '0) begin
                  phase <= PH_FINAL;
                  cnt   <= CNT_W'(FINAL_LEN - 1);
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            PH_FINAL: begin
               if (cnt == '0) begin
                  phase <= PH_RESOLVE;
                  cnt   <= CNT_W'(CODE_W - 1);
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: begin
               if (cnt == '0) begin
                  phase <= PH_IDLE;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
         endcase
      end
   end

   assign launch     = (phase == PH_IDLE) && start;
   assign res_active = (phase == PH_RESOLVE);
   assign res_last   = res_active && (cnt == '0);
   assign bit_idx    = cnt[IDX_W-1:0];

endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
   parameter int CODE_W = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       active,
   input  logic [$clog2(CODE_W)-1:0]  bit_idx,
   input  logic                       cmp_hi,
   output logic [CODE_W-1:0]          trial,
   output logic [CODE_W-1:0]          settled
);

   localparam int IDX_W = $clog2(CODE_W);

   logic [CODE_W-1:0] kept;

   generate
      for (genvar i = 0; i < CODE_W; i++) begin : g_bit
         logic on_bit;
         assign on_bit     = active && (bit_idx == IDX_W'(i));
         assign trial[i]   = active && (kept[i] || on_bit);
         assign settled[i] = on_bit ? ~cmp_hi : kept[i];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               kept[i] <= 1'b0;
            end else if (clear) begin
               kept[i] <= 1'b0;
            end else if (on_bit) begin
               kept[i] <= ~cmp_hi;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sar_result_hold.sv
module sar_result_hold #(
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [CODE_W-1:0] settled,
   output logic [CODE_W-1:0] code,
   output logic              done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         done <= 1'b0;
      end else begin
         done <= capture;
         if (capture) begin
            code <= settled;
         end
      end
   end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
   import sar_pkg::*;
#(
   parameter int CODE_W    = 10,
   parameter int SEL_W     = 2,
   parameter int INIT_BASE = 2,
   parameter int FINAL_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              bypass_i,
   input  logic [SEL_W-1:0]  init_sel_i,
   input  logic              cmp_hi_i,
   output logic [CODE_W-1:0] dac_code_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [CODE_W-1:0] code_o
);

   localparam int IDX_W = $clog2(CODE_W);

   generate
      if (CODE_W < 2) begin : g_bad_width
         $error("sar_conv_ctrl: CODE_W must be at least 2");
      end
      if (FINAL_LEN < 1) begin : g_bad_final
         $error("sar_conv_ctrl: FINAL_LEN must be at least 1");
      end
      if (INIT_BASE < 1 || SEL_W < 1) begin : g_bad_init
         $error("sar_conv_ctrl: INIT_BASE and SEL_W must be at least 1");
      end
   endgenerate

   sar_phase_t        phase;
   logic              launch;
   logic              res_active;
   logic              res_last;
   logic [IDX_W-1:0]  bit_idx;
   logic [CODE_W-1:0] settled;

   sar_phase_seq #(
      .CODE_W    (CODE_W),
      .SEL_W     (SEL_W),
      .INIT_BASE (INIT_BASE),
      .FINAL_LEN (FINAL_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .bypass     (bypass_i),
      .init_sel   (init_sel_i),
      .phase      (phase),
      .launch     (launch),
      .res_active (res_active),
      .res_last   (res_last),
      .bit_idx    (bit_idx)
   );

   sar_search_reg #(
      .CODE_W (CODE_W)
   ) u_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (launch),
      .active  (res_active),
      .bit_idx (bit_idx),
      .cmp_hi  (cmp_hi_i),
      .trial   (dac_code_o),
      .settled (settled)
   );

   sar_result_hold #(
      .CODE_W (CODE_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (res_last),
      .settled (settled),
      .code    (code_o),
      .done    (done_o)
   );

   assign busy_o = (phase != PH_IDLE);

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk
   import sar_pkg::*;
#(
   parameter int CODE_W = 10
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start_i,
   input logic                      bypass_i,
   input logic                      cmp_hi_i,
   input logic [CODE_W-1:0]         dac_code_o,
   input logic                      busy_o,
   input logic                      done_o,
   input logic [CODE_W-1:0]         code_o,
   input sar_phase_t                phase,
   input logic [$clog2(CODE_W)-1:0] bit_idx
);

   localparam logic [CODE_W-1:0] HALF = CODE_W'(1) << (CODE_W - 1);

   p_half_scale_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RESOLVE && $past(phase) == PH_FINAL) |-> dac_code_o == HALF);

   p_bit_decide_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RESOLVE && bit_idx != '0) |=> dac_code_o[$past(bit_idx)] == !$past(cmp_hi_i));

   p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   p_bypass_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && bypass_i) |=> phase == PH_FINAL);

   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RESOLVE && bit_idx != '0 && start_i) |=> phase == PH_RESOLVE);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(code_o));

   p_dac_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_RESOLVE) |-> dac_code_o == '0);

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
   .CODE_W (CODE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .bypass_i   (bypass_i),
   .cmp_hi_i   (cmp_hi_i),
   .dac_code_o (dac_code_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .code_o     (code_o),
   .phase      (phase),
   .bit_idx    (bit_idx)
);

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;

   localparam int W  = 10;
   localparam int W8 = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          bypass = 1'b0;
   logic [1:0]    sel = 2'd0;
   int            ain = 0;
   int            ain8 = 85;

   logic [W-1:0]  dac, code;
   logic          busy, done;
   logic [W8-1:0] dac8, code8;
   logic          busy8, done8;
   logic          cmp, cmp8;

   assign cmp  = int'(dac)  > ain;
   assign cmp8 = int'(dac8) > ain8;

   always #2.5 clk = ~clk;

   sar_conv_ctrl u_sar_conv_ctrl (
      .clk (clk), .rst_n (rst_n), .start_i (start), .bypass_i (bypass),
      .init_sel_i (sel), .cmp_hi_i (cmp), .dac_code_o (dac),
      .busy_o (busy), .done_o (done), .code_o (code)
   );

   sar_conv_ctrl #(.CODE_W (W8)) u_sar_conv_ctrl_w8 (
      .clk (clk), .rst_n (rst_n), .start_i (start), .bypass_i (bypass),
      .init_sel_i (sel), .cmp_hi_i (cmp8), .dac_code_o (dac8),
      .busy_o (busy8), .done_o (done8), .code_o (code8)
   );

   typedef struct {
      int    code;
      int    cycles;
      string tag;
   } exp_t;

   exp_t sbq[$];
   int   checks = 0;
   int   errors = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // monitor: scoreboard pop and per-cycle output checks
   int   busy_cnt = 0;
   bit   first_seen = 0;
   bit   prev_done = 0;
   int   held = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done) chk(!done, "R8 done width", int'(done), 0);
         prev_done = done;
         if (busy) begin
            busy_cnt++;
            if (!first_seen && dac != '0) begin
               first_seen = 1;
               chk(dac == 10'd512, "R1 first trial", int'(dac), 512);
            end
            chk(int'(code) == held, "R9 hold during busy", int'(code), held);
         end
         if (done) begin
            chk(!busy, "R8 busy low at done", int'(busy), 0);
            if (sbq.size() == 0) begin
               chk(0, "R7 unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(int'(code) == e.code, {"R2/R3 code ", e.tag}, int'(code), e.code);
               chk(busy_cnt == e.cycles, {"R4 cycles ", e.tag}, busy_cnt, e.cycles);
            end
            busy_cnt = 0;
            first_seen = 0;
            held = int'(code);
         end
         if (done8) chk(int'(code8) == ain8, "R3 8-bit third", int'(code8), ain8);
      end
   end

   // driver: one conversion, optionally poking start mid-way
   task automatic conv(input int a, input bit byp, input int s,
                       input int ecyc, input string tag, input bit poke);
      exp_t e;
      @(negedge clk);
      ain = a;
      bypass = byp;
      sel = 2'(s);
      e.code = a;
      e.cycles = ecyc;
      e.tag = tag;
      sbq.push_back(e);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      bypass = 1'b0;
      if (poke) begin
         repeat (4) @(negedge clk);
         start = 1'b1;
         bypass = 1'b1;
         sel = 2'd0;
         @(negedge clk);
         start = 1'b0;
         bypass = 1'b0;
         repeat (8) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (sbq.size() == 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(!busy, "R10 reset busy", int'(busy), 0);
      chk(!done, "R10 reset done", int'(done), 0);
      chk(code == '0, "R10 reset code", int'(code), 0);
      chk(dac == '0, "R10 reset dac", int'(dac), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 select mapping: 2,4,8,16 initial clocks plus 2 + 10
      conv(341, 1'b0, 0, 14, "R6 sel0 third", 1'b0);
      conv(341, 1'b0, 1, 16, "R6 sel1", 1'b0);
      conv(341, 1'b0, 2, 20, "R6 sel2", 1'b0);
      conv(341, 1'b0, 3, 28, "R6 sel3", 1'b0);
      // R5 bypass removes the initial phase whatever the select
      conv(341, 1'b1, 3, 12, "R5 bypass", 1'b0);
      conv(0,    1'b1, 0, 12, "R3 zero", 1'b0);
      conv(1023, 1'b0, 0, 14, "R3 full", 1'b0);
      conv(512,  1'b0, 1, 16, "R3 half", 1'b0);
      conv(511,  1'b1, 2, 12, "R3 below half", 1'b0);
      conv(682,  1'b0, 0, 14, "R3 two thirds", 1'b0);
      // R7 start pokes during a long conversion
      conv(700,  1'b0, 3, 28, "R7 poke", 1'b1);
      for (int k = 0; k < 3; k++) begin
         chk(!busy, "R7 no restart", int'(busy), 0);
         chk(int'(code) == 700, "R9 hold idle", int'(code), 700);
         chk(dac == '0, "R10 dac idle", int'(dac), 0);
         @(negedge clk);
      end
      summary();
      $finish;
   end

endmodule